// File: doc/BRIEF.md
# Selective Cache Flush Controller

This controller sits beside a write-back L1 cache and performs the coherence work that software asks for at synchronization points. It keeps a valid bit for every line and a dirty bit for every word. It handles three synchronization commands: entering a critical section (acquire), leaving one (release) and a barrier. For each command it visits every line in turn and sends each dirty line to memory once. A writeback carries a per-word enable mask, so only the words this cache modified overwrite memory. Words written by other agents in the same line are left alone, which makes false sharing safe.

Acquire and barrier commands then drop the whole cache contents. They also pulse a request to clear the page-owner map. A release only cleans the lines and leaves them resident. The cache reports store hits (with a word mask) and line fills through a small update port. The controller reads the data of the line it is visiting through a combinational read port into the cache data array.

Top module: `selflush_ctrl`

## Requirements
- R1: After reset the controller is idle (`busy` low, `cmd_ready` high), every line is invalid, and `wb_valid`, `done` and `map_inv` are low.
- R2: A store hit (`st_en`) on a line sets that line valid and ORs `st_mask` into its word dirty bits, with bit i standing for word i. A fill (`fill_en`) sets the line valid and clears all of its dirty bits.
- R3: During a command, lines are visited in ascending index order. Exactly one writeback is issued for each line with at least one dirty word, and clean lines produce none.
- R4: `wb_mask` equals the dirty bits of the line being written. `wb_data` carries word i in bits [32i+31:32i], and a word whose mask bit is clear is driven as zero.
- R5: While `wb_valid` is high and `wb_ready` is low, `wb_valid`, `wb_line`, `wb_mask` and `wb_data` hold steady.
- R6: A line's dirty bits are cleared in the cycle its writeback is accepted. A second command therefore writes that line again only if it was stored to in between.
- R7: `cmd_kind` encoding: 2'b01 acquire, 2'b10 release, 2'b11 barrier. A request with 2'b00 is ignored and the controller stays idle.
- R8: After an acquire or a barrier, every line is invalid. After a release, the set of valid lines is unchanged.
- R9: `map_inv` pulses for one cycle together with `done` for acquire and barrier, and stays low for release.
- R10: `busy` is high from the cycle after a command is accepted until the `done` cycle, inclusive. `done` is a one-cycle pulse that follows the acceptance of the last writeback, and `busy` is low in the next cycle.
- R11: A command presented while the controller is busy is refused and has no effect.
- R12: Store and fill updates presented while the controller is busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Synchronization command request |
| cmd_kind | input | 2 | Command type (01 acquire, 10 release, 11 barrier) |
| cmd_ready | output | 1 | High when a command can be accepted |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle pulse at command completion |
| map_inv | output | 1 | One-cycle request to clear the page-owner map |
| st_en | input | 1 | Store hit update |
| st_line | input | 6 | Line index of the store hit |
| st_mask | input | 8 | Words written by the store |
| fill_en | input | 1 | Line fill update |
| fill_line | input | 6 | Line index of the fill |
| line_valid | output | 64 | Valid bit of every line, bit n for line n |
| rd_line | output | 6 | Line index read from the cache data array |
| rd_data | input | 256 | Data of line `rd_line` |
| wb_valid | output | 1 | Writeback request |
| wb_ready | input | 1 | Memory accepts the writeback |
| wb_line | output | 6 | Line index being written back |
| wb_mask | output | 8 | Per-word write enables |
| wb_data | output | 256 | Line data, clean words zeroed |

## Verification
The assertions assume that `cmd_kind` is stable while `cmd_valid` is high. They also assume that a store and a fill never target the same line in the same cycle, and that `rd_data` is a pure function of `rd_line`. The stimulus drives only the encoded command values and issues at most one update per cycle. It models the cache data array as a fixed pattern indexed by line and word, so all three assumptions hold. `wb_ready` follows an irregular stall pattern that the controller cannot predict, which keeps the hold-steady properties under real pressure.

// File: rtl/selflush_pkg.sv
package selflush_pkg;

  typedef enum logic [1:0] {
    SYNC_NONE    = 2'b00,
    SYNC_ACQUIRE = 2'b01,
    SYNC_RELEASE = 2'b10,
    SYNC_BARRIER = 2'b11
  } sync_kind_e;

  typedef enum logic [1:0] {
    WK_IDLE  = 2'b00,
    WK_SCAN  = 2'b01,
    WK_CLOSE = 2'b10
  } walk_state_e;

  // Commands that discard the cache contents after cleaning.
  function automatic logic kind_drops_lines(sync_kind_e k);
    return (k == SYNC_ACQUIRE) || (k == SYNC_BARRIER);
  endfunction

  // Commands that clear the page-owner map.
  function automatic logic kind_drops_map(sync_kind_e k);
    return (k == SYNC_ACQUIRE) || (k == SYNC_BARRIER);
  endfunction

  // A request that names a real command.
  function automatic logic kind_is_command(logic [1:0] k);
    return k != SYNC_NONE;
  endfunction

endpackage

// File: rtl/selflush_lines.sv
module selflush_lines
  import selflush_pkg::*;
#(
  parameter int LINES = 64,
  parameter int WORDS = 8,
  parameter int IDXW  = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_en,
  input  logic             st_en,
  input  logic [IDXW-1:0]  st_line,
  input  logic [WORDS-1:0] st_mask,
  input  logic             fill_en,
  input  logic [IDXW-1:0]  fill_line,
  input  logic             clr_en,
  input  logic [IDXW-1:0]  clr_line,
  input  logic             inval_all,
  input  logic [IDXW-1:0]  look_idx,
  output logic [WORDS-1:0] look_dirty,
  output logic [LINES-1:0] valid_vec
);

  logic [WORDS-1:0] dirty_q [LINES];
  logic [LINES-1:0] valid_q;

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic st_hit, fill_hit, clr_hit;
    assign st_hit   = upd_en && st_en   && (st_line   == IDXW'(g));
    assign fill_hit = upd_en && fill_en && (fill_line == IDXW'(g));
    assign clr_hit  = clr_en && (clr_line == IDXW'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_q[g] <= 1'b0;
        dirty_q[g] <= '0;
      end else begin
        if (inval_all)               valid_q[g] <= 1'b0;
        else if (st_hit || fill_hit) valid_q[g] <= 1'b1;

        if (clr_hit)       dirty_q[g] <= '0;
        else if (fill_hit) dirty_q[g] <= st_hit ? st_mask : '0;
        else if (st_hit)   dirty_q[g] <= dirty_q[g] | st_mask;
      end
    end
  end

  assign look_dirty = dirty_q[look_idx];
  assign valid_vec  = valid_q;

  // Checker state: remember the line whose writeback was accepted.
  logic            chk_clr_q;
  logic [IDXW-1:0] chk_line_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_clr_q  <= 1'b0;
      chk_line_q <= '0;
    end else begin
      chk_clr_q  <= clr_en;
      chk_line_q <= clr_line;
    end
  end

  assert_dirty_cleared_R6: assert property (@(posedge clk) disable iff (!rst_n)
    chk_clr_q |-> (dirty_q[chk_line_q] == '0));

  assert_all_dropped_R8: assert property (@(posedge clk) disable iff (!rst_n)
    inval_all |=> (valid_vec == '0));

  assert_frozen_while_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_en && !inval_all) |=> $stable(valid_vec));

endmodule

// File: rtl/selflush_walker.sv
module selflush_walker
  import selflush_pkg::*;
#(
  parameter int LINES = 64,
  parameter int IDXW  = $clog2(LINES)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic [1:0]      cmd_kind,
  input  logic            cur_dirty,
  input  logic            wb_ready,
  output logic            busy,
  output logic [IDXW-1:0] walk_idx,
  output logic            wb_valid,
  output logic            wb_take,
  output logic            done,
  output logic            map_inv,
  output logic            inval_all
);

  localparam logic [IDXW-1:0] LAST_IDX = IDXW'(LINES - 1);

  walk_state_e     state_q;
  sync_kind_e      kind_q;
  logic [IDXW-1:0] idx_q;

  // Named internal events.
  logic accept, step, at_last;
  assign accept  = (state_q == WK_IDLE) && cmd_valid && kind_is_command(cmd_kind);
  assign at_last = (idx_q == LAST_IDX);
  assign step    = (state_q == WK_SCAN) && (!cur_dirty || wb_ready);

  assign wb_valid  = (state_q == WK_SCAN) && cur_dirty;
  assign wb_take   = wb_valid && wb_ready;
  assign done      = (state_q == WK_CLOSE);
  assign map_inv   = done && kind_drops_map(kind_q);
  assign inval_all = done && kind_drops_lines(kind_q);
  assign busy      = (state_q != WK_IDLE);
  assign walk_idx  = idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= WK_IDLE;
      kind_q  <= SYNC_RELEASE;
      idx_q   <= '0;
    end else begin
      unique case (state_q)
        WK_IDLE: if (accept) begin
          kind_q  <= sync_kind_e'(cmd_kind);
          idx_q   <= '0;
          state_q <= WK_SCAN;
        end
        WK_SCAN: if (step) begin
          if (at_last) state_q <= WK_CLOSE;
          else         idx_q   <= idx_q + 1'b1;
        end
        WK_CLOSE: state_q <= WK_IDLE;
        default:  state_q <= WK_IDLE;
      endcase
    end
  end

  assert_start_needs_cmd_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cmd_valid));

  assert_kind_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> $stable(kind_q));

  assert_ascending_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !at_last) |=> (walk_idx == $past(walk_idx) + 1'b1));

  assert_map_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    map_inv |-> done);

  assert_done_then_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  assert_done_no_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !wb_valid);

endmodule

// File: rtl/selflush_ctrl.sv
module selflush_ctrl
  import selflush_pkg::*;
#(
  parameter int LINES = 64,
  parameter int WORDS = 8,
  parameter int WBITS = 32,
  localparam int IDXW  = $clog2(LINES),
  localparam int LBITS = WORDS * WBITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_kind,
  output logic             cmd_ready,
  output logic             busy,
  output logic             done,
  output logic             map_inv,
  input  logic             st_en,
  input  logic [IDXW-1:0]  st_line,
  input  logic [WORDS-1:0] st_mask,
  input  logic             fill_en,
  input  logic [IDXW-1:0]  fill_line,
  output logic [LINES-1:0] line_valid,
  output logic [IDXW-1:0]  rd_line,
  input  logic [LBITS-1:0] rd_data,
  output logic             wb_valid,
  input  logic             wb_ready,
  output logic [IDXW-1:0]  wb_line,
  output logic [WORDS-1:0] wb_mask,
  output logic [LBITS-1:0] wb_data
);

  logic [IDXW-1:0]  walk_idx;
  logic [WORDS-1:0] look_dirty;
  logic             wb_take, inval_all;

  selflush_walker #(.LINES(LINES), .IDXW(IDXW)) walker_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_kind  (cmd_kind),
    .cur_dirty (|look_dirty),
    .wb_ready  (wb_ready),
    .busy      (busy),
    .walk_idx  (walk_idx),
    .wb_valid  (wb_valid),
    .wb_take   (wb_take),
    .done      (done),
    .map_inv   (map_inv),
    .inval_all (inval_all)
  );

  selflush_lines #(.LINES(LINES), .WORDS(WORDS), .IDXW(IDXW)) lines_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .upd_en     (!busy),
    .st_en      (st_en),
    .st_line    (st_line),
    .st_mask    (st_mask),
    .fill_en    (fill_en),
    .fill_line  (fill_line),
    .clr_en     (wb_take),
    .clr_line   (walk_idx),
    .inval_all  (inval_all),
    .look_idx   (walk_idx),
    .look_dirty (look_dirty),
    .valid_vec  (line_valid)
  );

  assign cmd_ready = !busy;
  assign rd_line   = walk_idx;
  assign wb_line   = walk_idx;
  assign wb_mask   = wb_valid ? look_dirty : '0;

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    assign wb_data[w*WBITS +: WBITS] = wb_mask[w] ? rd_data[w*WBITS +: WBITS] : '0;
  end

  assert_held_under_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_line) && $stable(wb_mask)
                                 && $stable(wb_data)));

  assert_no_clean_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> (wb_mask != '0));

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!wb_valid && !done && !map_inv));

endmodule

// File: tb/selflush_ctrl_tb_top.sv
module selflush_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int LINES = 64;
  localparam int WORDS = 8;
  localparam int NVEC  = 8;
  localparam int WATCHDOG = 20000;

  typedef struct packed {
    logic [5:0] l_a;
    logic [7:0] m_a;
    logic [5:0] l_b;
    logic [7:0] m_b;
    logic [1:0] kind;
  } vec_t;

  // kind: 01 acquire, 10 release, 11 barrier. Mask 0 means no store.
  localparam vec_t VECS [NVEC] = '{
    '{6'd0,  8'h01, 6'd63, 8'h80, 2'b10},
    '{6'd5,  8'hFF, 6'd6,  8'h0F, 2'b10},
    '{6'd5,  8'hF0, 6'd0,  8'h00, 2'b01},
    '{6'd10, 8'hAA, 6'd10, 8'h55, 2'b11},
    '{6'd0,  8'h00, 6'd0,  8'h00, 2'b10},
    '{6'd33, 8'h3C, 6'd32, 8'hC3, 2'b10},
    '{6'd1,  8'h02, 6'd62, 8'h40, 2'b01},
    '{6'd63, 8'hFF, 6'd2,  8'h11, 2'b11}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_valid = 1'b0;
  logic [1:0]   cmd_kind = 2'b00;
  logic         cmd_ready, busy, done, map_inv;
  logic         st_en = 1'b0;
  logic [5:0]   st_line = '0;
  logic [7:0]   st_mask = '0;
  logic         fill_en = 1'b0;
  logic [5:0]   fill_line = '0;
  logic [63:0]  line_valid;
  logic [5:0]   rd_line;
  logic [255:0] rd_data;
  logic         wb_valid;
  logic         wb_ready = 1'b0;
  logic [5:0]   wb_line;
  logic [7:0]   wb_mask;
  logic [255:0] wb_data;

  selflush_ctrl dut_i (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0;
  int n_fails  = 0;
  int beats    = 0;
  int exp_ptr  = 0;
  int rdy_cnt  = 0;
  logic [7:0]  m_dirty [LINES];
  logic [63:0] m_valid = '0;

  function automatic logic [31:0] word_pat(logic [5:0] l, int w);
    return {8'hA5, 2'b00, l, 13'h0, 3'(w)};
  endfunction

  function automatic logic [255:0] exp_data(logic [5:0] l, logic [7:0] m);
    logic [255:0] d = '0;
    for (int w = 0; w < WORDS; w++) if (m[w]) d[w*32 +: 32] = word_pat(l, w);
    return d;
  endfunction

  always_comb
    for (int w = 0; w < WORDS; w++) rd_data[w*32 +: 32] = word_pat(rd_line, w);

  task automatic check(input bit ok, input string tag, input logic [255:0] act,
                       input logic [255:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  endtask

  // Writeback monitor with stall generator.
  int e_line;
  always @(negedge clk) begin
    if (rst_n) begin
      rdy_cnt++;
      wb_ready = ((rdy_cnt % 3) != 2) && ((rdy_cnt % 7) != 4);
      if (wb_valid && wb_ready) begin
        e_line = -1;
        for (int l = LINES - 1; l >= exp_ptr; l--) if (m_dirty[l] != 0) e_line = l;
        check(int'(wb_line) == e_line, "R3 ascending dirty line", wb_line, e_line);
        check(wb_mask == m_dirty[wb_line], "R4 word mask", wb_mask, m_dirty[wb_line]);
        check(wb_data == exp_data(wb_line, m_dirty[wb_line]), "R4 masked data",
              wb_data, exp_data(wb_line, m_dirty[wb_line]));
        m_dirty[wb_line] = '0;
        exp_ptr = int'(wb_line) + 1;
        beats++;
      end
    end
  end

  task automatic upd(input bit is_fill, input logic [5:0] l, input logic [7:0] m,
                     input bit track);
    @(negedge clk);
    if (is_fill) begin fill_en = 1'b1; fill_line = l; end
    else begin st_en = 1'b1; st_line = l; st_mask = m; end
    @(negedge clk);
    fill_en = 1'b0; st_en = 1'b0;
    if (track) begin
      m_valid[l] = 1'b1;
      if (is_fill) m_dirty[l] = '0; else m_dirty[l] = m_dirty[l] | m;
    end
  endtask

  task automatic run_cmd(input logic [1:0] k);
    int exp_beats = 0;
    int b0 = beats;
    bit drops = (k == 2'b01) || (k == 2'b11);
    bit left = 0;
    for (int l = 0; l < LINES; l++) if (m_dirty[l] != 0) exp_beats++;
    exp_ptr = 0;
    @(negedge clk); cmd_valid = 1'b1; cmd_kind = k;
    @(negedge clk); cmd_valid = 1'b0;
    check(busy == 1'b1, "R10 busy after accept", busy, 1);
    while (!done) @(negedge clk);
    check(beats - b0 == exp_beats, "R3 one writeback per dirty line", beats - b0, exp_beats);
    for (int l = 0; l < LINES; l++) if (m_dirty[l] != 0) left = 1;
    check(!left, "R10 done after all writebacks", left, 0);
    check(map_inv == drops, "R9 map clear pulse", map_inv, drops);
    check(busy == 1'b1, "R10 busy in done cycle", busy, 1);
    if (drops) m_valid = '0;
    @(negedge clk);
    check(busy == 1'b0 && done == 1'b0, "R10 idle after done", {busy, done}, 0);
    check(line_valid == m_valid, "R8 valid lines after command", line_valid, m_valid);
  endtask

  initial begin
    for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int l = 0; l < LINES; l++) m_dirty[l] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(busy == 0 && cmd_ready == 1, "R1 idle after reset", {busy, cmd_ready}, 1);
    check(line_valid == '0, "R1 all lines invalid", line_valid, 0);
    check(!wb_valid && !done && !map_inv, "R1 outputs quiet", {wb_valid, done, map_inv}, 0);

    // Vector table
    for (int v = 0; v < NVEC; v++) begin
      if (VECS[v].m_a != 0) upd(0, VECS[v].l_a, VECS[v].m_a, 1);
      if (VECS[v].m_b != 0) upd(0, VECS[v].l_b, VECS[v].m_b, 1);
      check(line_valid == m_valid, "R2 store marks line valid", line_valid, m_valid);
      run_cmd(VECS[v].kind);
    end

    // R6: second release after release writes nothing
    upd(0, 6'd9, 8'h81, 1);
    run_cmd(2'b10);
    run_cmd(2'b10);

    // R2: fill clears dirty bits
    upd(0, 6'd7, 8'h0F, 1);
    upd(1, 6'd7, 8'h00, 1);
    check(line_valid[7] == 1'b1, "R2 fill keeps line valid", line_valid[7], 1);
    run_cmd(2'b10);

    // R7: kind 00 ignored
    @(negedge clk); cmd_valid = 1'b1; cmd_kind = 2'b00;
    @(negedge clk); cmd_valid = 1'b0;
    check(busy == 1'b0, "R7 null command ignored", busy, 0);
    @(negedge clk);
    check(busy == 1'b0 && line_valid == m_valid, "R7 state unchanged", busy, 0);

    // R11 and R12: command and store while busy
    upd(0, 6'd4, 8'h01, 1);
    @(negedge clk); cmd_valid = 1'b1; cmd_kind = 2'b10;
    @(negedge clk); cmd_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(cmd_ready == 1'b0, "R11 not ready while busy", cmd_ready, 0);
    cmd_valid = 1'b1; cmd_kind = 2'b11;
    st_en = 1'b1; st_line = 6'd20; st_mask = 8'hFF;
    @(negedge clk);
    cmd_valid = 1'b0; st_en = 1'b0;
    while (!done) @(negedge clk);
    check(map_inv == 1'b0, "R11 refused barrier left release", map_inv, 0);
    @(negedge clk);
    check(line_valid[20] == 1'b0, "R12 store while busy ignored", line_valid[20], 0);
    check(line_valid[4] == 1'b1, "R11 refused barrier did not invalidate", line_valid[4], 1);
    begin
      bit extra = 0;
      for (int c = 0; c < 80; c++) begin
        @(negedge clk);
        if (done || busy) extra = 1;
      end
      check(!extra, "R11 no second command run", extra, 0);
    end
    run_cmd(2'b10);

    finish_run();
  end

endmodule